// File: doc/BRIEF.md
# Link Mode Resolution Controller

This block chooses the speed and duplex that a 10/100 Ethernet port runs at. When the link partner is sending fast link pulses and its ability page has arrived, the block ANDs the local and partner ability masks and takes the best shared mode from a fixed ranking. When no fast link pulses are seen, it uses parallel detection instead. Three abstract indications (normal link pulses, 10 Mb/s receive data and 100 Mb/s idle) pick the speed, and the duplex is always half.

Once a mode is chosen, the block raises a completion bit and a one-hot mode status, and holds both until one of two things happens: link is lost, or the restart control is written. A hardware reset also clears them. If the two ability masks share no mode, the block flags a fault instead of completing. Pulse detection, page exchange and code word formats are handled by other blocks.

Top module: `link_mode_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, an_done, an_fault, restart_pend and mode_stat are all zero after that edge.
- R2: Masks use bit 3 = 100 Mb/s full duplex, bit 2 = 100 Mb/s half duplex, bit 1 = 10 Mb/s full duplex, bit 0 = 10 Mb/s half duplex. With flp_present and page_valid high in the detect state, mode_stat becomes the one-hot highest set bit of local_abil AND partner_abil, one edge later.
- R3: an_done rises on the same edge that mode_stat takes its resolved value, and whenever an_done is high mode_stat has exactly one bit set.
- R4: If local_abil AND partner_abil is zero when a page is resolved, an_fault goes high, an_done stays low and mode_stat stays zero.
- R5: While completed, mode_stat and an_done do not change in response to ability, pulse, page or parallel-detect inputs. They change only on link_lost, restart_wr or reset.
- R6: Parallel detection acts only while flp_present is low. With flp_present high, the detect indications are ignored, and the ability masks are ignored when flp_present is low.
- R7: Parallel detection gives bit 0 (10 Mb/s half) for nlp_det or rx10_det, and bit 2 (100 Mb/s half) for idle100_det. idle100_det wins when it is present together with either of the others.
- R8: A restart_wr pulse sets restart_pend on the next edge and clears an_done, an_fault and mode_stat. restart_pend self-clears one edge later, and no resolution takes place while it is high, so with steady inputs the result returns two edges after the pulse.
- R9: link_lost high at an edge clears an_done, an_fault and mode_stat on that edge, and the block stays unresolved for as long as link_lost is held.
- R10: link_lost takes priority over restart_wr in the same cycle: restart_pend stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flp_present | input | 1 | Fast link pulses are being received |
| page_valid | input | 1 | Partner ability page has been received |
| local_abil | input | 4 | Local advertised modes (bit map as in R2) |
| partner_abil | input | 4 | Partner advertised modes (bit map as in R2) |
| nlp_det | input | 1 | Normal link pulses detected |
| rx10_det | input | 1 | 10 Mb/s receive data detected |
| idle100_det | input | 1 | 100 Mb/s idle detected |
| link_lost | input | 1 | Link loss indication |
| restart_wr | input | 1 | Write pulse to the restart control bit |
| an_done | output | 1 | Resolution complete |
| an_fault | output | 1 | No common mode between the two masks |
| mode_stat | output | 4 | One-hot resolved mode (bit map as in R2) |
| restart_pend | output | 1 | Restart control bit readback, self-clearing |

## Verification
Every cycle, the assertions check that the completion bit and a one-hot mode always go together, that the fault and completion bits exclude each other, and that a held result stays stable. They also check that link loss and restart clear the status one edge later, that restart self-clears, and that a mode found without fast link pulses is half duplex. The scenarios alone show the choice of the right mode under the priority ranking, the fault on disjoint masks, the mapping from parallel detection, the two-edge gap before a result after restart, and the ordering of simultaneous link loss and restart.

// File: rtl/lmr_pkg.sv
// Package: shared mode encoding and controller state type.
// Assumes four modes, ranked by bit index (higher index = preferred).
package lmr_pkg;
    localparam int NMODE  = 4;
    localparam int M10HD  = 0;
    localparam int M10FD  = 1;
    localparam int M100HD = 2;
    localparam int M100FD = 3;

    typedef logic [NMODE-1:0] mode_mask_t;

    typedef enum logic [1:0] {
        ST_DETECT = 2'd0,
        ST_LINKED = 2'd1,
        ST_FAULT  = 2'd2
    } lmr_state_t;
endpackage

// File: rtl/lmr_prio_pick.sv
// Module: picks the highest set bit of a request vector as a one-hot grant.
// Assumes a higher bit index means a higher priority. Purely combinational.
module lmr_prio_pick #(
    parameter int W = 4
) (
    input  logic [W-1:0] req,
    output logic [W-1:0] grant,
    output logic         any
);
    // Scan upward so that the highest set bit is the one that survives.
    always_comb begin
        grant = '0;
        for (int i = 0; i < W; i++) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

    // Any request present.
    assign any = |req;
endmodule

// File: rtl/lmr_pardet.sv
// Module: maps the parallel-detect indications to a half-duplex mode.
// Assumes the indications are already qualified by the caller. 100 Mb/s idle wins.
module lmr_pardet
    import lmr_pkg::*;
(
    input  logic       nlp_det,
    input  logic       rx10_det,
    input  logic       idle100_det,
    output mode_mask_t pd_mode,
    output logic       pd_hit
);
    // Choose the speed, always with half duplex.
    always_comb begin
        pd_mode = '0;
        if (idle100_det)
            pd_mode[M100HD] = 1'b1;
        else if (nlp_det || rx10_det)
            pd_mode[M10HD] = 1'b1;
    end

    // A mode was detected.
    assign pd_hit = |pd_mode;
endmodule

// File: rtl/lmr_fsm.sv
// Module: the resolution state machine and its status registers.
// Assumes the common-mode pick and the parallel-detect mapping are computed outside.
// Exit priority: reset, then link loss, then restart, then resolution.
module lmr_fsm
    import lmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flp_present,
    input  logic       page_valid,
    input  logic       common_hit,
    input  mode_mask_t common_mode,
    input  logic       pd_hit,
    input  mode_mask_t pd_mode,
    input  logic       link_lost,
    input  logic       restart_wr,
    output logic       an_done,
    output logic       an_fault,
    output mode_mask_t mode_stat,
    output logic       restart_pend
);
    lmr_state_t state_q;

    // State and status update, one register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_DETECT;
            an_done      <= 1'b0;
            an_fault     <= 1'b0;
            mode_stat    <= '0;
            restart_pend <= 1'b0;
        end else if (link_lost) begin
            state_q      <= ST_DETECT;
            an_done      <= 1'b0;
            an_fault     <= 1'b0;
            mode_stat    <= '0;
            restart_pend <= 1'b0;
        end else if (restart_wr) begin
            state_q      <= ST_DETECT;
            an_done      <= 1'b0;
            an_fault     <= 1'b0;
            mode_stat    <= '0;
            restart_pend <= 1'b1;
        end else begin
            restart_pend <= 1'b0;
            case (state_q)
                ST_DETECT: begin
                    if (!restart_pend) begin
                        if (flp_present) begin
                            if (page_valid) begin
                                if (common_hit) begin
                                    state_q   <= ST_LINKED;
                                    an_done   <= 1'b1;
                                    mode_stat <= common_mode;
                                end else begin
                                    state_q  <= ST_FAULT;
                                    an_fault <= 1'b1;
                                end
                            end
                        end else if (pd_hit) begin
                            state_q   <= ST_LINKED;
                            an_done   <= 1'b1;
                            mode_stat <= pd_mode;
                        end
                    end
                end
                ST_LINKED: state_q <= ST_LINKED;
                ST_FAULT:  state_q <= ST_FAULT;
                default: begin
                    state_q   <= ST_DETECT;
                    an_done   <= 1'b0;
                    an_fault  <= 1'b0;
                    mode_stat <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/link_mode_ctrl.sv
// Module: top of the link mode resolution controller.
// Resolves speed/duplex from ability masks, or falls back to parallel detection.
// Assumes all inputs are synchronous to clk.
module link_mode_ctrl
    import lmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flp_present,
    input  logic             page_valid,
    input  logic [NMODE-1:0] local_abil,
    input  logic [NMODE-1:0] partner_abil,
    input  logic             nlp_det,
    input  logic             rx10_det,
    input  logic             idle100_det,
    input  logic             link_lost,
    input  logic             restart_wr,
    output logic             an_done,
    output logic             an_fault,
    output logic [NMODE-1:0] mode_stat,
    output logic             restart_pend
);
    mode_mask_t shared_abil;
    mode_mask_t best_mode;
    logic       best_hit;
    mode_mask_t pd_mode;
    logic       pd_hit;

    // Modes that both sides advertise.
    assign shared_abil = local_abil & partner_abil;

    lmr_prio_pick #(.W(NMODE)) pick_i (
        .req   (shared_abil),
        .grant (best_mode),
        .any   (best_hit)
    );

    lmr_pardet pd_i (
        .nlp_det     (nlp_det),
        .rx10_det    (rx10_det),
        .idle100_det (idle100_det),
        .pd_mode     (pd_mode),
        .pd_hit      (pd_hit)
    );

    lmr_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .flp_present  (flp_present),
        .page_valid   (page_valid),
        .common_hit   (best_hit),
        .common_mode  (best_mode),
        .pd_hit       (pd_hit),
        .pd_mode      (pd_mode),
        .link_lost    (link_lost),
        .restart_wr   (restart_wr),
        .an_done      (an_done),
        .an_fault     (an_fault),
        .mode_stat    (mode_stat),
        .restart_pend (restart_pend)
    );
endmodule

// File: rtl/lmr_chk.sv
// Checker: temporal properties of link_mode_ctrl, attached by bind.
module lmr_chk
    import lmr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             flp_present,
    input logic [NMODE-1:0] local_abil,
    input logic [NMODE-1:0] partner_abil,
    input logic             link_lost,
    input logic             restart_wr,
    input logic             an_done,
    input logic             an_fault,
    input logic [NMODE-1:0] mode_stat,
    input logic             restart_pend
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !an_done && !an_fault && !restart_pend && mode_stat == '0);

    // R3
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        an_done |-> $countones(mode_stat) == 1);

    // R4
    fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        an_fault |-> !an_done && mode_stat == '0);

    // R4
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(an_fault) |-> $past((local_abil & partner_abil) == '0));

    // R5
    hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        an_done && !link_lost && !restart_wr |=> an_done && $stable(mode_stat));

    // R6
    pd_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(an_done) && !$past(flp_present) |-> !mode_stat[M100FD] && !mode_stat[M10FD]);

    // R8
    restart_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_wr && !link_lost |=> restart_pend && !an_done && !an_fault && mode_stat == '0);

    // R8
    restart_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_pend && !restart_wr |=> !restart_pend && !an_done);

    // R9
    loss_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_lost |=> !an_done && !an_fault && mode_stat == '0);

    // R10
    loss_over_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_lost |=> !restart_pend);
endmodule

bind link_mode_ctrl lmr_chk chk_i (.*);

// File: tb/link_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module link_mode_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flp_present = 1'b0, page_valid = 1'b0;
    logic [3:0] local_abil = '0, partner_abil = '0;
    logic       nlp_det = 1'b0, rx10_det = 1'b0, idle100_det = 1'b0;
    logic       link_lost = 1'b0, restart_wr = 1'b0;
    logic       an_done, an_fault, restart_pend;
    logic [3:0] mode_stat;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    link_mode_ctrl dut_i (.*);

    // Vector: cls[2] flp pv local[4] partner[4] nlp rx10 idle | done fault mode[4]
    // cls: 0 -> R2/R3, 1 -> R4, 2 -> R6, 3 -> R7
    localparam int NV = 13;
    localparam logic [20:0] VEC [NV] = '{
        {2'd0, 1'b1, 1'b1, 4'b1111, 4'b1111, 3'b000, 1'b1, 1'b0, 4'b1000},
        {2'd0, 1'b1, 1'b1, 4'b1111, 4'b0111, 3'b000, 1'b1, 1'b0, 4'b0100},
        {2'd0, 1'b1, 1'b1, 4'b0011, 4'b1011, 3'b000, 1'b1, 1'b0, 4'b0010},
        {2'd0, 1'b1, 1'b1, 4'b0001, 4'b1111, 3'b000, 1'b1, 1'b0, 4'b0001},
        {2'd1, 1'b1, 1'b1, 4'b1010, 4'b0101, 3'b000, 1'b0, 1'b1, 4'b0000},
        {2'd0, 1'b1, 1'b1, 4'b0101, 4'b1100, 3'b111, 1'b1, 1'b0, 4'b0100},
        {2'd2, 1'b1, 1'b0, 4'b1111, 4'b1111, 3'b111, 1'b0, 1'b0, 4'b0000},
        {2'd3, 1'b0, 1'b0, 4'b0000, 4'b0000, 3'b100, 1'b1, 1'b0, 4'b0001},
        {2'd3, 1'b0, 1'b0, 4'b0000, 4'b0000, 3'b010, 1'b1, 1'b0, 4'b0001},
        {2'd3, 1'b0, 1'b0, 4'b0000, 4'b0000, 3'b001, 1'b1, 1'b0, 4'b0100},
        {2'd3, 1'b0, 1'b0, 4'b0000, 4'b0000, 3'b111, 1'b1, 1'b0, 4'b0100},
        {2'd2, 1'b0, 1'b0, 4'b1111, 4'b1111, 3'b000, 1'b0, 1'b0, 4'b0000},
        {2'd2, 1'b0, 1'b1, 4'b1111, 4'b1111, 3'b100, 1'b1, 1'b0, 4'b0001}
    };

    function automatic string cls_name(input logic [1:0] c);
        case (c)
            2'd0:    return "R2/R3";
            2'd1:    return "R4";
            2'd2:    return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (done fault pend mode)", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [6:0] obs();
        return {an_done, an_fault, restart_pend, mode_stat};
    endfunction

    task automatic clear_link();
        link_lost = 1'b1;
        tick();
        link_lost = 1'b0;
    endtask

    task automatic set_in(input logic f, input logic p, input logic [3:0] l,
                          input logic [3:0] r, input logic [2:0] pd);
        flp_present = f; page_valid = p; local_abil = l; partner_abil = r;
        {nlp_det, rx10_det, idle100_det} = pd;
    endtask

    // Watchdog: a hung run counts as one failure and still prints the summary.
    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick();
        // R1: reset state
        check("R1", obs(), 7'b000_0000);
        // R1: reset holds even with resolvable inputs
        set_in(1'b1, 1'b1, 4'b1111, 4'b1111, 3'b000);
        tick();
        check("R1", obs(), 7'b000_0000);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            set_in(1'b0, 1'b0, 4'b0000, 4'b0000, 3'b000);
            clear_link();
            set_in(VEC[i][18], VEC[i][17], VEC[i][16:13], VEC[i][12:9], VEC[i][8:6]);
            tick();
            check(cls_name(VEC[i][20:19]), obs(),
                  {VEC[i][5], VEC[i][4], 1'b0, VEC[i][3:0]});
        end

        // R5: hold against changing inputs
        set_in(1'b1, 1'b1, 4'b1111, 4'b1111, 3'b000);
        clear_link();
        tick();
        check("R5", obs(), 7'b100_1000);
        set_in(1'b0, 1'b1, 4'b0001, 4'b0001, 3'b111);
        tick();
        tick();
        check("R5", obs(), 7'b100_1000);

        // R8: restart sequence, result returns two edges later
        set_in(1'b1, 1'b1, 4'b1111, 4'b0011, 3'b000);
        restart_wr = 1'b1;
        tick();
        restart_wr = 1'b0;
        check("R8", obs(), 7'b001_0000);
        tick();
        check("R8", obs(), 7'b000_0000);
        tick();
        check("R8", obs(), 7'b100_0010);

        // R8: restart clears a fault
        set_in(1'b1, 1'b1, 4'b1000, 4'b0001, 3'b000);
        clear_link();
        tick();
        check("R4", obs(), 7'b010_0000);
        restart_wr = 1'b1;
        tick();
        restart_wr = 1'b0;
        check("R8", obs(), 7'b001_0000);

        // R9: link loss clears and holds while asserted
        set_in(1'b0, 1'b0, 4'b0000, 4'b0000, 3'b001);
        clear_link();
        tick();
        check("R9", obs(), 7'b100_0100);
        link_lost = 1'b1;
        tick();
        check("R9", obs(), 7'b000_0000);
        tick();
        check("R9", obs(), 7'b000_0000);
        link_lost = 1'b0;
        tick();
        check("R9", obs(), 7'b100_0100);

        // R10: link loss beats restart in the same cycle
        link_lost = 1'b1;
        restart_wr = 1'b1;
        tick();
        link_lost = 1'b0;
        restart_wr = 1'b0;
        check("R10", obs(), 7'b000_0000);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule